// File: doc/BRIEF.md
# Standard-Definition Component Test Pattern Generator

This block produces full-field 10-bit 4:2:2 component video test signals for standard-definition rasters. Its output goes straight to a serializer input. One 4-bit select code sets three things. It picks the aspect ratio, which gives 1440 active words per line at the 27 MHz word clock or 1920 at 36 MHz. It picks the line standard, 525 or 625 lines. It picks one of four pictures: flat black, the PLL pathological signal, the equalizer pathological signal, or 75% eight-bar colour bars. The bar edges are abrupt and have no filtered samples. Every line carries timing reference words at its start (end of active video) and just before its active span (start of active video). The words between them are blanking. The active span is multiplexed Cb, Y, Cr, Y.

The select code arrives on a 10-bit input. A code is accepted only when the upper six bits are zero. A control state machine with three states handles start and stop:
- ST_IDLE waits for the enable. On enable with a valid code it moves to ST_RUN (transition START). On enable with an invalid code it moves to ST_REJECT (transition REFUSE).
- ST_RUN generates words. When the enable drops it returns to ST_IDLE (transition HALT).
- ST_REJECT outputs nothing. When the enable drops it returns to ST_IDLE (transition RELEASE).

The code is captured on START and held for the whole run. Each run begins at line 0, word 0. Lines are numbered from zero. Field 1 holds lines 0 to ceil(N/2)-1 and field 2 holds the rest, where N is the line count. The first VBL lines of each field are vertical blanking; VBL is a per-standard parameter. The line lengths, the active widths, the line counts and VBL are all parameters. Their defaults are the broadcast values.

Top module: `sdtv_pattern_gen`

## Requirements
- R1: After reset, and in ST_IDLE or ST_REJECT, `vid_word` is 000h and `vid_sol`, `vid_field` and `vid_vblank` are 0.
- R2: Words per line are selected by select bits 3 and 2. Bit 3 = 0 gives 4:3 and bit 3 = 1 gives 16:9. Bit 2 = 0 gives 525 lines and bit 2 = 1 gives 625 lines. The defaults are 1716, 1728, 2288 and 2304 words for 525/4:3, 625/4:3, 525/16:9 and 625/16:9. The active width is ACT_43 (1440) for 4:3 and ACT_169 (1920) for 16:9. Active words occupy the last words of each line.
- R3: Line words 0..3 are 3FFh, 000h, 000h, S with H=1. The four words just before the active span are the same sequence with H=0. S has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1:0 = 0.
- R4: Blanking words, and the whole active span of vertical-blanking lines, are 200h at even line word positions and 040h at odd ones.
- R5: In the active span, with a = word - first active word, a mod 4 = 0 carries Cb, 1 carries Y, 2 carries Cr and 3 carries Y.
- R6: Select bits 1:0 = 00 give black: Y 040h, Cb/Cr 200h.
- R7: Bits 1:0 = 10 give the equalizer pathological signal (Cb/Cr 300h, Y 198h) on the first floor(n/2) active lines of each field, where n is that field's active line count. The remaining active lines are black.
- R8: Bits 1:0 = 01 give black on the first floor(n/2) active lines of each field and the PLL pathological signal (Cb/Cr 200h, Y 110h) on the rest.
- R9: Bits 1:0 = 11 give eight bars, each ACT/8 words wide, with abrupt edges. The bars run left to right as white, yellow, cyan, green, magenta, red, blue, black, with (Y,Cb,Cr) values (2D0,200,200), (288,0B0,238), (20C,270,0B0), (1C0,120,0E8), (150,2E0,318), (104,190,350), (08C,350,1C8) and (040,200,200) in hex.
- R10: `vid_sol` is 1 only with word 0 of each line. `vid_field` is 1 on field 2 lines. `vid_vblank` is 1 on the first VBL lines of each field. F and V in S match these outputs.
- R11: A rising enable with a valid code makes the word for line 0, word 0 appear two clock edges later. Changes to the select during a run are ignored. After the enable falls, the output is quiet from the second edge on. The next run restarts at line 0.
- R12: If any of select bits 9..4 is 1 when the enable rises, nothing is generated until the enable has fallen and risen again with a valid code.
- R13: After the last line of the frame, generation continues with line 0 of field 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpg_en | input | 1 | Generation enable |
| tpg_sel | input | 10 | Select code; bits 3:0 carry the code, bits 9:4 must be zero |
| vid_word | output | 10 | Multiplexed 4:2:2 output word |
| vid_sol | output | 1 | Marks word 0 (first end-of-active-video word) of each line |
| vid_field | output | 1 | Field 2 indicator |
| vid_vblank | output | 1 | Vertical blanking line indicator |

## Verification
A wrong word or line counter shifts the reference words within one line. A missing or misplaced 3FFh then shows on the very next line, or `vid_sol` stops arriving at the selected line length. A wrong line count or field boundary shows within one frame: F or V in the status word disagrees with `vid_field`/`vid_vblank`, or the pathological split lands on the wrong lines. A stuck control state shows within two edges of an enable change, either as output during a rejected start or as no 3FFh where a run should begin. The bench compares every word and marker over a full frame plus the wrap line for all four patterns, and covers both standards and both aspect ratios across those runs.

// File: rtl/spg_pkg.sv
package spg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REJECT = 2'd2
    } spg_state_e;

    typedef enum logic [1:0] {
        PAT_FLAT  = 2'd0,
        PAT_LOCK  = 2'd1,
        PAT_EQUAL = 2'd2,
        PAT_BARS  = 2'd3
    } spg_pat_e;

    typedef struct packed {
        logic [9:0] cb;
        logic [9:0] y;
        logic [9:0] cr;
    } spg_ycc_t;

    localparam logic [9:0] LVL_BLANK_Y = 10'h040;
    localparam logic [9:0] LVL_BLANK_C = 10'h200;
    localparam logic [9:0] TRS_ONES    = 10'h3FF;
    localparam logic [9:0] TRS_ZERO    = 10'h000;

    localparam spg_ycc_t YCC_BLACK = '{cb: 10'h200, y: 10'h040, cr: 10'h200};
    localparam spg_ycc_t YCC_EQ    = '{cb: 10'h300, y: 10'h198, cr: 10'h300};
    localparam spg_ycc_t YCC_PLL   = '{cb: 10'h200, y: 10'h110, cr: 10'h200};

    // Status word of a timing reference sequence with protection bits.
    function automatic logic [9:0] trs_status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    // 75% amplitude bar levels, bar 0 at the left edge.
    function automatic spg_ycc_t bar_level(input logic [2:0] idx);
        spg_ycc_t c;
        case (idx)
            3'd0:    c = '{cb: 10'h200, y: 10'h2D0, cr: 10'h200};
            3'd1:    c = '{cb: 10'h0B0, y: 10'h288, cr: 10'h238};
            3'd2:    c = '{cb: 10'h270, y: 10'h20C, cr: 10'h0B0};
            3'd3:    c = '{cb: 10'h120, y: 10'h1C0, cr: 10'h0E8};
            3'd4:    c = '{cb: 10'h2E0, y: 10'h150, cr: 10'h318};
            3'd5:    c = '{cb: 10'h190, y: 10'h104, cr: 10'h350};
            3'd6:    c = '{cb: 10'h350, y: 10'h08C, cr: 10'h1C8};
            default: c = YCC_BLACK;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl
    import spg_pkg::*;
#(
    parameter int SEL_W  = 10,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    output logic              run,
    output logic [CODE_W-1:0] code
);

    spg_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              sel_ok;

    assign sel_ok = (sel[SEL_W-1:CODE_W] == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en) state_d = sel_ok ? ST_RUN : ST_REJECT;
            ST_RUN:    if (!en) state_d = ST_IDLE;
            ST_REJECT: if (!en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              code_q <= '0;
        else if (state_q == ST_IDLE && en && sel_ok) code_q <= sel[CODE_W-1:0];
    end

    assign run  = (state_q == ST_RUN);
    assign code = code_q;

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q == ST_RUN)) |-> $stable(code_q)); // R11

    AST_REJECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT) |=> (state_q != ST_RUN)); // R12

endmodule

// File: rtl/spg_raster.sv
module spg_raster #(
    parameter int HW          = 12,
    parameter int LW          = 10,
    parameter int ACT_43      = 1440,
    parameter int ACT_169     = 1920,
    parameter int TOT_525_43  = 1716,
    parameter int TOT_625_43  = 1728,
    parameter int TOT_525_169 = 2288,
    parameter int TOT_625_169 = 2304,
    parameter int LINES_525   = 525,
    parameter int LINES_625   = 625,
    parameter int VBL_525     = 19,
    parameter int VBL_625     = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wide,
    input  logic          pal,
    output logic [HW-1:0] h_pos,
    output logic [HW-1:0] tot,
    output logic [HW-1:0] act_len,
    output logic          fld,
    output logic          vbl,
    output logic          late_half
);

    localparam int F2S_525 = (LINES_525 + 1) / 2;
    localparam int F2S_625 = (LINES_625 + 1) / 2;

    logic [HW-1:0] h_q;
    logic [LW-1:0] ln_q;
    logic [LW-1:0] nlines, f2s, vb, lif, fact;

    always_comb begin
        if (wide) tot = pal ? HW'(TOT_625_169) : HW'(TOT_525_169);
        else      tot = pal ? HW'(TOT_625_43)  : HW'(TOT_525_43);
        act_len = wide ? HW'(ACT_169) : HW'(ACT_43);
        nlines  = pal ? LW'(LINES_625) : LW'(LINES_525);
        f2s     = pal ? LW'(F2S_625)   : LW'(F2S_525);
        vb      = pal ? LW'(VBL_625)   : LW'(VBL_525);
        fld       = (ln_q >= f2s);
        lif       = fld ? (ln_q - f2s) : ln_q;
        fact      = fld ? (nlines - f2s - vb) : (f2s - vb);
        vbl       = (lif < vb);
        late_half = ((lif - vb) >= (fact >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q  <= '0;
            ln_q <= '0;
        end else if (!run) begin
            h_q  <= '0;
            ln_q <= '0;
        end else if (h_q == tot - 1'b1) begin
            h_q  <= '0;
            ln_q <= (ln_q == nlines - 1'b1) ? '0 : ln_q + 1'b1;
        end else begin
            h_q  <= h_q + 1'b1;
        end
    end

    assign h_pos = h_q;

    AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (h_q < tot)); // R2

    AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && h_q != '0) |-> $stable(ln_q)); // R10

    AST_LN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ln_q < nlines)); // R13

endmodule

// File: rtl/spg_pixel.sv
module spg_pixel
    import spg_pkg::*;
#(
    parameter int HW      = 12,
    parameter int ACT_43  = 1440,
    parameter int ACT_169 = 1920
) (
    input  logic [HW-1:0] h_pos,
    input  logic [HW-1:0] tot,
    input  logic [HW-1:0] act_len,
    input  logic          wide,
    input  logic          fld,
    input  logic          vbl,
    input  logic          late_half,
    input  logic [1:0]    pat,
    output logic [9:0]    word,
    output logic          sol
);

    localparam int BW_43  = ACT_43 / 8;
    localparam int BW_169 = ACT_169 / 8;

    logic [HW-1:0] act0, sav0, a_idx, bar_w;
    logic [2:0]    bar_idx;
    spg_ycc_t      ycc;
    logic [9:0]    trs_w;

    always_comb begin
        act0  = tot - act_len;
        sav0  = act0 - HW'(4);
        a_idx = h_pos - act0;
        bar_w = wide ? HW'(BW_169) : HW'(BW_43);
        bar_idx = 3'd0;
        for (int i = 1; i < 8; i++) begin
            if (a_idx >= HW'(i) * bar_w) bar_idx = 3'(i);
        end
    end

    always_comb begin
        unique case (spg_pat_e'(pat))
            PAT_FLAT:  ycc = YCC_BLACK;
            PAT_LOCK:  ycc = late_half ? YCC_PLL : YCC_BLACK;
            PAT_EQUAL: ycc = late_half ? YCC_BLACK : YCC_EQ;
            PAT_BARS:  ycc = bar_level(bar_idx);
            default:   ycc = YCC_BLACK;
        endcase
    end

    always_comb begin
        logic [1:0] k;
        logic       h_bit;
        h_bit = (h_pos < HW'(4));
        k     = h_bit ? h_pos[1:0] : 2'(h_pos - sav0);
        unique case (k)
            2'd0:    trs_w = TRS_ONES;
            2'd3:    trs_w = trs_status(fld, vbl, h_bit);
            default: trs_w = TRS_ZERO;
        endcase
    end

    always_comb begin
        if (h_pos < HW'(4) || (h_pos >= sav0 && h_pos < act0)) begin
            word = trs_w;
        end else if (h_pos < act0 || vbl) begin
            word = h_pos[0] ? LVL_BLANK_Y : LVL_BLANK_C;
        end else begin
            unique case (a_idx[1:0])
                2'd0:    word = ycc.cb;
                2'd2:    word = ycc.cr;
                default: word = ycc.y;
            endcase
        end
    end

    assign sol = (h_pos == '0);

endmodule

// File: rtl/sdtv_pattern_gen.sv
module sdtv_pattern_gen
    import spg_pkg::*;
#(
    parameter int ACT_43      = 1440,
    parameter int ACT_169     = 1920,
    parameter int TOT_525_43  = 1716,
    parameter int TOT_625_43  = 1728,
    parameter int TOT_525_169 = 2288,
    parameter int TOT_625_169 = 2304,
    parameter int LINES_525   = 525,
    parameter int LINES_625   = 625,
    parameter int VBL_525     = 19,
    parameter int VBL_625     = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tpg_en,
    input  logic [9:0] tpg_sel,
    output logic [9:0] vid_word,
    output logic       vid_sol,
    output logic       vid_field,
    output logic       vid_vblank
);

    localparam int TOT_A   = (TOT_525_43 > TOT_625_43) ? TOT_525_43 : TOT_625_43;
    localparam int TOT_B   = (TOT_525_169 > TOT_625_169) ? TOT_525_169 : TOT_625_169;
    localparam int TOT_MAX = (TOT_A > TOT_B) ? TOT_A : TOT_B;
    localparam int LN_MAX  = (LINES_525 > LINES_625) ? LINES_525 : LINES_625;
    localparam int HW      = $clog2(TOT_MAX + 1);
    localparam int LW      = $clog2(LN_MAX + 1);

    logic          run;
    logic [3:0]    code;
    logic [HW-1:0] h_pos, tot, act_len;
    logic          fld, vbl, late_half;
    logic [9:0]    px_word;
    logic          px_sol;

    spg_ctrl #(.SEL_W(10), .CODE_W(4)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(tpg_en), .sel(tpg_sel),
        .run(run), .code(code)
    );

    spg_raster #(
        .HW(HW), .LW(LW), .ACT_43(ACT_43), .ACT_169(ACT_169),
        .TOT_525_43(TOT_525_43), .TOT_625_43(TOT_625_43),
        .TOT_525_169(TOT_525_169), .TOT_625_169(TOT_625_169),
        .LINES_525(LINES_525), .LINES_625(LINES_625),
        .VBL_525(VBL_525), .VBL_625(VBL_625)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .run(run), .wide(code[3]), .pal(code[2]),
        .h_pos(h_pos), .tot(tot), .act_len(act_len),
        .fld(fld), .vbl(vbl), .late_half(late_half)
    );

    spg_pixel #(.HW(HW), .ACT_43(ACT_43), .ACT_169(ACT_169)) u_pixel (
        .h_pos(h_pos), .tot(tot), .act_len(act_len), .wide(code[3]),
        .fld(fld), .vbl(vbl), .late_half(late_half), .pat(code[1:0]),
        .word(px_word), .sol(px_sol)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_word   <= '0;
            vid_sol    <= 1'b0;
            vid_field  <= 1'b0;
            vid_vblank <= 1'b0;
        end else begin
            vid_word   <= run ? px_word : '0;
            vid_sol    <= run & px_sol;
            vid_field  <= run & fld;
            vid_vblank <= run & vbl;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (vid_word == '0 && !vid_sol && !vid_field && !vid_vblank)); // R1

    AST_SOL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_sol && run) |=> (vid_word == TRS_ZERO)); // R3

    AST_SOL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        vid_sol |-> (vid_word == TRS_ONES)); // R3

    AST_FIELD_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_field) |-> vid_sol); // R10

endmodule

// File: tb/tb_sdtv_pattern_gen.sv
module tb_sdtv_pattern_gen;

    localparam int A43 = 32, A169 = 64;
    localparam int T525A = 44, T625A = 48, T525B = 76, T625B = 80;
    localparam int L525 = 10, L625 = 12, VB = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tpg_en = 1'b0;
    logic [9:0] tpg_sel = '0;
    logic [9:0] vid_word;
    logic       vid_sol, vid_field, vid_vblank;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sdtv_pattern_gen #(
        .ACT_43(A43), .ACT_169(A169),
        .TOT_525_43(T525A), .TOT_625_43(T625A),
        .TOT_525_169(T525B), .TOT_625_169(T625B),
        .LINES_525(L525), .LINES_625(L625),
        .VBL_525(VB), .VBL_625(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tpg_en(tpg_en), .tpg_sel(tpg_sel),
        .vid_word(vid_word), .vid_sol(vid_sol),
        .vid_field(vid_field), .vid_vblank(vid_vblank)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int actv, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
        end
    endtask

    function automatic int m_tot(input logic [3:0] c);
        if (c[3]) return c[2] ? T625B : T525B;
        return c[2] ? T625A : T525A;
    endfunction

    function automatic int m_lines(input logic [3:0] c);
        return c[2] ? L625 : L525;
    endfunction

    function automatic bit m_fld(input logic [3:0] c, input int ln);
        return ln >= (m_lines(c) + 1) / 2;
    endfunction

    function automatic int m_lif(input logic [3:0] c, input int ln);
        return m_fld(c, ln) ? ln - (m_lines(c) + 1) / 2 : ln;
    endfunction

    function automatic bit m_vbl(input logic [3:0] c, input int ln);
        return m_lif(c, ln) < VB;
    endfunction

    function automatic logic [9:0] m_trs(input int k, input bit f, input bit v, input bit h);
        if (k == 0) return 10'h3FF;
        if (k != 3) return 10'h000;
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    function automatic logic [9:0] m_word(input logic [3:0] c, input int h, input int ln);
        int tot, act, a0, s0, a, half, nact, f2;
        bit f, v, late;
        logic [9:0] cb, y, cr;
        logic [9:0] by [8];
        logic [9:0] bb [8];
        logic [9:0] br [8];
        by = '{10'h2D0, 10'h288, 10'h20C, 10'h1C0, 10'h150, 10'h104, 10'h08C, 10'h040};
        bb = '{10'h200, 10'h0B0, 10'h270, 10'h120, 10'h2E0, 10'h190, 10'h350, 10'h200};
        br = '{10'h200, 10'h238, 10'h0B0, 10'h0E8, 10'h318, 10'h350, 10'h1C8, 10'h200};
        tot = m_tot(c);
        act = c[3] ? A169 : A43;
        a0 = tot - act;
        s0 = a0 - 4;
        f = m_fld(c, ln);
        v = m_vbl(c, ln);
        f2 = (m_lines(c) + 1) / 2;
        nact = f ? (m_lines(c) - f2 - VB) : (f2 - VB);
        half = nact / 2;
        late = (m_lif(c, ln) - VB) >= half;
        if (h < 4) return m_trs(h, f, v, 1'b1);
        if (h >= s0 && h < a0) return m_trs(h - s0, f, v, 1'b0);
        if (h < a0 || v) return (h % 2 == 1) ? 10'h040 : 10'h200;
        a = h - a0;
        cb = 10'h200; y = 10'h040; cr = 10'h200;
        case (c[1:0])
            2'b10: if (!late) begin cb = 10'h300; y = 10'h198; cr = 10'h300; end
            2'b01: if (late)  begin cb = 10'h200; y = 10'h110; cr = 10'h200; end
            2'b11: begin
                cb = bb[a / (act / 8)]; y = by[a / (act / 8)]; cr = br[a / (act / 8)];
            end
            default: ;
        endcase
        if (a % 4 == 0) return cb;
        if (a % 4 == 2) return cr;
        return y;
    endfunction

    // After return, the current negedge shows line 0 word 0.
    task automatic start_run(input logic [9:0] s);
        @(negedge clk);
        tpg_sel = s;
        tpg_en = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        tpg_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sweep(input logic [3:0] c, input string req, input logic [9:0] sel_after);
        int bad_d = 0, bad_m = 0;
        int fa = 0, fe = 0;
        start_run({6'b0, c});
        tpg_sel = sel_after;
        for (int ln = 0; ln <= m_lines(c); ln++) begin
            for (int h = 0; h < m_tot(c); h++) begin
                int lm;
                logic [9:0] e;
                lm = ln % m_lines(c);
                e = m_word(c, h, lm);
                if (vid_word !== e) begin
                    if (bad_d == 0) begin fa = vid_word; fe = e; end
                    bad_d++;
                end
                if (vid_sol !== (h == 0) || vid_field !== m_fld(c, lm) ||
                    vid_vblank !== m_vbl(c, lm)) bad_m++;
                @(negedge clk);
            end
        end
        stop_run();
        chk(bad_d == 0, req, $sformatf("frame words code %0h", c), fa, fe);
        chk(bad_m == 0, "R10", $sformatf("markers code %0h mismatches", c), bad_m, 0);
    endtask

    task automatic test_reset();
        chk(vid_word == 10'h000, "R1", "word after reset", vid_word, 0);
        chk({vid_sol, vid_field, vid_vblank} == 3'b000, "R1", "markers after reset",
            {vid_sol, vid_field, vid_vblank}, 0);
    endtask

    task automatic test_trs_literal();
        logic [9:0] w [12];
        start_run(10'h000);
        for (int i = 0; i < 12; i++) begin
            w[i] = vid_word;
            @(negedge clk);
        end
        chk(w[0] == 10'h3FF && w[1] == 10'h000 && w[2] == 10'h000, "R3", "EAV preamble",
            {w[0], w[1], w[2]}, {10'h3FF, 10'h000, 10'h000});
        chk(w[3] == 10'h2D8, "R3", "EAV status line 0", w[3], 10'h2D8);
        chk(w[11] == 10'h2AC, "R3", "SAV status line 0", w[11], 10'h2AC);
        chk(w[4] == 10'h200 && w[5] == 10'h040, "R4", "horizontal blanking", {w[4], w[5]},
            {10'h200, 10'h040});
        stop_run();
    endtask

    task automatic test_bars_literal();
        logic [9:0] cbw, yw, crw;
        start_run(10'h003);
        repeat (T525A - 1) @(negedge clk);
        chk(vid_sol == 1'b0, "R2", "no line start at word 43", vid_sol, 0);
        @(negedge clk);
        chk(vid_sol == 1'b1, "R2", "line start after 44 words", vid_sol, 1);
        repeat (2 * T525A + 16) @(negedge clk);
        cbw = vid_word; @(negedge clk);
        yw = vid_word;  @(negedge clk);
        crw = vid_word;
        chk(cbw == 10'h0B0 && yw == 10'h288 && crw == 10'h238, "R9",
            "yellow bar on line 3", {cbw, yw, crw}, {10'h0B0, 10'h288, 10'h238});
        stop_run();
    endtask

    task automatic test_invalid();
        int bad = 0;
        @(negedge clk);
        tpg_sel = 10'h043;
        tpg_en = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (vid_word != 0 || vid_sol) bad++;
        end
        chk(bad == 0, "R12", "output during rejected start", bad, 0);
        tpg_sel = 10'h003;
        repeat (20) begin
            @(negedge clk);
            if (vid_word != 0 || vid_sol) bad++;
        end
        chk(bad == 0, "R12", "valid code without new enable edge", bad, 0);
        stop_run();
        start_run(10'h003);
        chk(vid_word == 10'h3FF && vid_sol, "R12", "run after re-enable", vid_word, 10'h3FF);
        stop_run();
    endtask

    task automatic test_stop_restart();
        int bad = 0;
        start_run(10'h003);
        repeat (57) @(negedge clk);
        tpg_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        repeat (30) begin
            if (vid_word != 0 || vid_sol || vid_field || vid_vblank) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R11", "quiet after enable low", bad, 0);
        start_run(10'h003);
        chk(vid_word == 10'h3FF && vid_sol && !vid_field && vid_vblank, "R11",
            "restart at line 0 word 0", {vid_word, vid_sol, vid_field, vid_vblank},
            {10'h3FF, 3'b101});
        stop_run();
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_trs_literal();
        test_bars_literal();
        sweep(4'h0, "R6", 10'h000);           // black, 4:3, 525 (R4 R5 R13)
        sweep(4'h5, "R8", 10'h005);           // PLL pathological, 4:3, 625
        sweep(4'hA, "R7", 10'h00A);           // EQ pathological, 16:9, 525
        sweep(4'hF, "R9", 10'h00F);           // bars, 16:9, 625
        sweep(4'h3, "R11", 10'h00C);          // select changed mid-run is ignored
        test_invalid();
        test_stop_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule